// File: doc/BRIEF.md
# Protected SMM memory window decoder

This block keeps one 8-bit control register for extended system-management memory and uses it, together with a few chip-level inputs, to steer every processor memory request. Two protected ranges are decoded. The first is a high alias window of 128 KB at 0xFEDA0000. When that window is enabled, a request that lands in it is translated down onto the legacy area at 0x000A0000. The second is a management-mode segment carved out just under the graphics reservation at the top of low memory. A request that hits that segment without the management-mode flag is sent downstream instead of to DRAM.

The register also holds a sticky violation flag. The flag records any touch of either protected range that comes from outside management mode while the open override is low. Software clears the flag by writing 1 to it. Once the lock input has been seen, the enable and size fields stop accepting writes until the next reset. Routing and translation are combinational. Only the register and the lock are clocked.

Top module: `smm_window_decode`

## Requirements
- R1: After synchronous reset the readback is 0x38: bits 5, 4 and 3 always read as 1, and every writable bit and the violation flag read as 0.
- R2: When the global enable and bit 7 are both 1, a request address in 0xFEDA0000..0xFEDBFFFF comes out as 0x000A0000 plus its low 17 bits. In every other case the output address equals the request address.
- R3: Bits 2:1 set the segment size: code 00 gives 1 MB, 01 gives 2 MB, and 10 gives 8 MB.
- R4: The segment covers addresses from (top − graphics MB × 2^20 − size) inclusive up to (top − graphics MB × 2^20) exclusive.
- R5: The segment is active only when the global enable and bit 0 are both 1. With size code 11 it never matches.
- R6: A valid request that hits the active segment without the management-mode flag raises the downstream route. Every other valid request raises the DRAM route. With no valid request, both routes are 0.
- R7: The violation flag (bit 6) sets at the clock edge after a valid request that hits the enabled high window or the active segment, provided the management-mode flag is 0 and the open override is 0. It does not set in any other case.
- R8: Writing 1 to bit 6 clears the flag. Writing 0 to bit 6 leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.
- R9: From the cycle the lock input is first high, bits 7, 2:1 and 0 ignore writes until reset, even after the lock input falls. Bit 6 can still be cleared.
- R10: The route and translated-address outputs follow the current request and register state in the same cycle, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | Lock request; the lock it sets is sticky until reset |
| glob_en | input | 1 | Global enable for protected memory |
| open_ovr | input | 1 | Open override; suppresses the violation flag |
| tolum | input | 32 | Top of low memory, as a byte address |
| gfx_mb | input | 8 | Graphics reservation size in MB |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register readback |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_smm | input | 1 | Request issued in management mode |
| rsp_addr | output | 32 | Translated address |
| to_dram | output | 1 | Route request to DRAM |
| to_down | output | 1 | Route request downstream |

## Verification
The bench probes the segment edges one byte inside and one byte outside the range, because a design with an inclusive top or an off-by-one base sends the edge address the wrong way. It also selects the reserved size code: a design that does not treat code 11 as disabled still claims a range there. The flag tests run a set and a clear in the same cycle, and also write 0 to the flag. A design that gives the clear priority, or that clears on any write, loses a violation. The lock test writes new fields in the same cycle the lock rises and again after the lock falls. A design that registers the lock late, or drops it when the input falls, lets those writes through.

// File: rtl/smmw_pkg.sv
package smmw_pkg;

    localparam int MB_SHIFT = 20;
    localparam int WIN_BITS = 17;
    localparam logic [31:0] HI_BASE = 32'hFEDA_0000;
    localparam logic [31:0] LO_BASE = 32'h000A_0000;
    localparam logic [7:0]  FIXED_ONES = 8'h38;

    typedef enum logic [1:0] {
        SZ_1M   = 2'b00,
        SZ_2M   = 2'b01,
        SZ_8M   = 2'b10,
        SZ_RSVD = 2'b11
    } seg_size_e;

    typedef struct packed {
        logic      hi_en;
        logic      viol;
        seg_size_e seg_sz;
        logic      seg_en;
    } ctl_t;

    function automatic logic [3:0] seg_mb(seg_size_e code);
        case (code)
            SZ_1M:   return 4'd1;
            SZ_2M:   return 4'd2;
            SZ_8M:   return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/smmw_ctl_reg.sv
module smmw_ctl_reg
    import smmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lock_in,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       viol_set,
    output ctl_t       ctl,
    output logic [7:0] rdata
);
    logic locked;
    logic lock_now;
    logic unused_wd;

    assign lock_now  = locked | lock_in;
    assign unused_wd = ^wdata[5:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            locked     <= 1'b0;
            ctl.hi_en  <= 1'b0;
            ctl.viol   <= 1'b0;
            ctl.seg_sz <= SZ_1M;
            ctl.seg_en <= 1'b0;
        end else begin
            locked   <= lock_now;
            ctl.viol <= viol_set | (ctl.viol & ~(we & wdata[6]));
            if (we && !lock_now) begin
                ctl.hi_en  <= wdata[7];
                ctl.seg_sz <= seg_size_e'(wdata[2:1]);
                ctl.seg_en <= wdata[0];
            end
        end
    end

    assign rdata = FIXED_ONES | {ctl.hi_en, ctl.viol, 3'b000, ctl.seg_sz, ctl.seg_en};

endmodule

// File: rtl/smmw_hi_alias.sv
module smmw_hi_alias
    import smmw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int TAG_W = ADDR_W - WIN_BITS;
    localparam logic [ADDR_W-1:0] HI_B = ADDR_W'(HI_BASE);
    localparam logic [ADDR_W-1:0] LO_B = ADDR_W'(LO_BASE);

    assign hit = en && (addr[ADDR_W-1:WIN_BITS] == HI_B[ADDR_W-1:WIN_BITS]);

    always_comb begin
        addr_out = addr;
        if (hit) begin
            addr_out = {LO_B[ADDR_W-1:WIN_BITS], addr[WIN_BITS-1:0]};
        end
    end

    logic unused_tag;
    assign unused_tag = ^{HI_B[WIN_BITS-1:0], LO_B[WIN_BITS-1:0], TAG_W[0]};

endmodule

// File: rtl/smmw_seg_dec.sv
module smmw_seg_dec
    import smmw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GFX_W  = 8
) (
    input  logic              act,
    input  seg_size_e         code,
    input  logic [ADDR_W-1:0] tolum,
    input  logic [GFX_W-1:0]  gfx_mb,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W-1:0] seg_top;
    logic [ADDR_W-1:0] seg_len;
    logic [ADDR_W-1:0] seg_base;

    assign seg_top  = tolum - (ADDR_W'(gfx_mb) << MB_SHIFT);
    assign seg_len  = ADDR_W'(seg_mb(code)) << MB_SHIFT;
    assign seg_base = seg_top - seg_len;

    assign hit = act && (code != SZ_RSVD) && (addr >= seg_base) && (addr < seg_top);

endmodule

// File: rtl/smm_window_decode.sv
module smm_window_decode
    import smmw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GFX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_in,
    input  logic              glob_en,
    input  logic              open_ovr,
    input  logic [ADDR_W-1:0] tolum,
    input  logic [GFX_W-1:0]  gfx_mb,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_smm,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              to_dram,
    output logic              to_down
);
    ctl_t ctl;
    logic hi_hit;
    logic seg_hit;
    logic viol_set;

    smmw_ctl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .lock_in  (lock_in),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .viol_set (viol_set),
        .ctl      (ctl),
        .rdata    (cfg_rdata)
    );

    smmw_hi_alias #(.ADDR_W(ADDR_W)) u_hi (
        .en       (glob_en & ctl.hi_en),
        .addr     (req_addr),
        .hit      (hi_hit),
        .addr_out (rsp_addr)
    );

    smmw_seg_dec #(.ADDR_W(ADDR_W), .GFX_W(GFX_W)) u_seg (
        .act    (glob_en & ctl.seg_en),
        .code   (ctl.seg_sz),
        .tolum  (tolum),
        .gfx_mb (gfx_mb),
        .addr   (req_addr),
        .hit    (seg_hit)
    );

    assign viol_set = req_valid & ~req_smm & ~open_ovr & (hi_hit | seg_hit);
    assign to_down  = req_valid & seg_hit & ~req_smm;
    assign to_dram  = req_valid & ~to_down;

endmodule

// File: rtl/smmw_checker.sv
module smmw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              lock_in,
    input logic              open_ovr,
    input logic              req_valid,
    input logic              req_smm,
    input logic [ADDR_W-1:0] req_addr,
    input logic              cfg_we,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              to_dram,
    input logic              to_down,
    input logic              hi_hit,
    input logic              seg_hit
);
    logic seen_lock;
    logic qual;

    always_ff @(posedge clk) begin
        if (rst) seen_lock <= 1'b0;
        else if (lock_in) seen_lock <= 1'b1;
    end

    assign qual = req_valid && !req_smm && !open_ovr && (hi_hit || seg_hit);

    // R2: the translated address lands in the legacy window and keeps its offset
    a_r2_alias_target: assert property (@(posedge clk) disable iff (rst)
        hi_hit |-> (rsp_addr[16:0] == req_addr[16:0]) && (rsp_addr[ADDR_W-1:17] == (ADDR_W-17)'(5)));

    // R6: exactly one route while a request is present, and none otherwise
    a_r6_one_route: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $onehot({to_dram, to_down}));
    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !to_dram && !to_down);

    // R7: a qualifying access sets the flag on the next edge
    a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
        qual |=> cfg_rdata[6]);

    // R8: the flag only drops through a write of one
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[6] && !(cfg_we && cfg_wdata[6]) |=> cfg_rdata[6]);
    a_r8_flag_clear: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[6] && cfg_we && cfg_wdata[6] && !qual |=> !cfg_rdata[6]);

    // R9: fields frozen once the lock has been seen
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        seen_lock |=> $stable({cfg_rdata[7], cfg_rdata[2:0]}));

endmodule

bind smm_window_decode smmw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lock_in   (lock_in),
    .open_ovr  (open_ovr),
    .req_valid (req_valid),
    .req_smm   (req_smm),
    .req_addr  (req_addr),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .rsp_addr  (rsp_addr),
    .to_dram   (to_dram),
    .to_down   (to_down),
    .hi_hit    (hi_hit),
    .seg_hit   (seg_hit)
);

// File: tb/sim_smm_window_decode.sv
`timescale 1ns/100ps
module sim_smm_window_decode;
    logic        clk = 1'b0;
    logic        rst, lock_in, glob_en, open_ovr, cfg_we, req_valid, req_smm;
    logic [31:0] tolum, req_addr, rsp_addr;
    logic [7:0]  gfx_mb, cfg_wdata, cfg_rdata;
    logic        to_dram, to_down;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    smm_window_decode u0 (
        .clk(clk), .rst(rst), .lock_in(lock_in), .glob_en(glob_en), .open_ovr(open_ovr),
        .tolum(tolum), .gfx_mb(gfx_mb), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr), .req_smm(req_smm),
        .rsp_addr(rsp_addr), .to_dram(to_dram), .to_down(to_down)
    );

    // top of low memory 1 GB, graphics 8 MB -> segment top 0x3F80_0000
    // fields: glob_en, cfg, smm, addr, exp_addr, exp_dram, exp_down
    localparam int NV = 17;
    localparam logic [75:0] VT [NV] = '{
        {1'b1, 8'h81, 1'b0, 32'hFEDA_1234, 32'h000A_1234, 1'b1, 1'b0}, // R2
        {1'b1, 8'h80, 1'b1, 32'hFEDB_FFFF, 32'h000B_FFFF, 1'b1, 1'b0}, // R2
        {1'b0, 8'h81, 1'b0, 32'hFEDA_0010, 32'hFEDA_0010, 1'b1, 1'b0}, // R2 global off
        {1'b1, 8'h00, 1'b0, 32'hFEDA_0010, 32'hFEDA_0010, 1'b1, 1'b0}, // R2 bit7 off
        {1'b1, 8'h01, 1'b0, 32'h3F70_0000, 32'h3F70_0000, 1'b0, 1'b1}, // R4 base
        {1'b1, 8'h01, 1'b0, 32'h3F6F_FFFF, 32'h3F6F_FFFF, 1'b1, 1'b0}, // R4 below
        {1'b1, 8'h01, 1'b0, 32'h3F7F_FFFF, 32'h3F7F_FFFF, 1'b0, 1'b1}, // R4 last
        {1'b1, 8'h01, 1'b0, 32'h3F80_0000, 32'h3F80_0000, 1'b1, 1'b0}, // R4 top excl
        {1'b1, 8'h01, 1'b1, 32'h3F75_0000, 32'h3F75_0000, 1'b1, 1'b0}, // R6 smm
        {1'b1, 8'h03, 1'b0, 32'h3F60_0000, 32'h3F60_0000, 1'b0, 1'b1}, // R3 2MB
        {1'b1, 8'h03, 1'b0, 32'h3F5F_FFFF, 32'h3F5F_FFFF, 1'b1, 1'b0}, // R3 2MB below
        {1'b1, 8'h05, 1'b0, 32'h3F00_0000, 32'h3F00_0000, 1'b0, 1'b1}, // R3 8MB
        {1'b1, 8'h05, 1'b0, 32'h3EFF_FFFF, 32'h3EFF_FFFF, 1'b1, 1'b0}, // R3 8MB below
        {1'b1, 8'h07, 1'b0, 32'h3F70_0000, 32'h3F70_0000, 1'b1, 1'b0}, // R5 reserved
        {1'b1, 8'h00, 1'b0, 32'h3F70_0000, 32'h3F70_0000, 1'b1, 1'b0}, // R5 bit0 off
        {1'b0, 8'h01, 1'b0, 32'h3F70_0000, 32'h3F70_0000, 1'b1, 1'b0}, // R5 global off
        {1'b1, 8'h02, 1'b0, 32'h3F60_0000, 32'h3F60_0000, 1'b1, 1'b0}  // R5 2MB disabled
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic hit_once(input logic smm, input logic ovr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h3F70_0000; req_smm = smm; open_ovr = ovr;
        @(negedge clk);
        req_valid = 1'b0; open_ovr = 1'b0; req_smm = 1'b0;
    endtask

    initial begin
        rst = 1'b1; lock_in = 0; glob_en = 1; open_ovr = 0; cfg_we = 0; cfg_wdata = 0;
        req_valid = 0; req_addr = 0; req_smm = 0; tolum = 32'h4000_0000; gfx_mb = 8'd8;
        do_reset();
        chk("R1 reset readback", 32'(cfg_rdata), 32'h38);
        chk("R6 idle routes", {30'd0, to_dram, to_down}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            wr(VT[i][74:67]);
            glob_en = VT[i][75];
            req_smm = VT[i][66];
            req_addr = VT[i][65:34];
            req_valid = 1'b1;
            #1;
            chk($sformatf("R10 vec%0d addr", i), rsp_addr, VT[i][33:2]);
            chk($sformatf("R6 vec%0d route", i), {30'd0, to_dram, to_down}, {30'd0, VT[i][1:0]});
            @(negedge clk);
            req_valid = 1'b0; glob_en = 1'b1;
        end

        // R7 flag timing and qualifiers
        do_reset();
        wr(8'h01);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h3F70_0000; req_smm = 0;
        #1 chk("R7 flag before edge", 32'(cfg_rdata[6]), 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 flag after edge", 32'(cfg_rdata[6]), 1);
        wr(8'h01);
        chk("R8 write zero keeps flag", 32'(cfg_rdata[6]), 1);
        wr(8'h41);
        chk("R8 write one clears", 32'(cfg_rdata), 32'h39);
        hit_once(1'b0, 1'b1);
        chk("R7 open override blocks", 32'(cfg_rdata[6]), 0);
        hit_once(1'b1, 1'b0);
        chk("R7 smm does not set", 32'(cfg_rdata[6]), 0);
        wr(8'h80);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'hFEDB_0000;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 high window sets", 32'(cfg_rdata[6]), 1);
        wr(8'h01);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h3F70_0000; cfg_we = 1'b1; cfg_wdata = 8'h41;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        chk("R8 set wins over clear", 32'(cfg_rdata[6]), 1);

        // R9 lock
        wr(8'h41);
        wr(8'h81);
        @(negedge clk);
        lock_in = 1'b1; cfg_we = 1'b1; cfg_wdata = 8'h06;
        @(negedge clk);
        lock_in = 1'b0; cfg_we = 1'b0;
        chk("R9 write with lock ignored", 32'(cfg_rdata), 32'hB9);
        wr(8'h00);
        chk("R9 lock sticky", 32'(cfg_rdata), 32'hB9);
        hit_once(1'b0, 1'b0);
        chk("R9 flag still sets", 32'(cfg_rdata), 32'hF9);
        wr(8'h40);
        chk("R9 flag clearable locked", 32'(cfg_rdata), 32'hB9);
        do_reset();
        chk("R1 reset after lock", 32'(cfg_rdata), 32'h38);
        wr(8'h05);
        chk("R9 reset releases lock", 32'(cfg_rdata), 32'h3D);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule